// File: doc/BRIEF.md
# Receive Frame Ring with Interrupt

This block buffers inbound frames in a fixed number of slots arranged as a ring. Frames arrive as a byte stream with a valid strobe and a last-byte marker. Each accepted frame is written into the slot at the write index together with its byte count. An occupancy counter tracks how many slots hold unread frames. A dequeue request picks the oldest stored frame, reports its length, and then streams its bytes out with a last-byte marker.

The oldest slot is not tracked by its own pointer. It is derived as the write index minus the occupancy, modulo the depth. A frame that starts while every slot is full is discarded in its entirety. A frame longer than a slot keeps only its leading bytes. Both cases raise a one-cycle error pulse.

A level interrupt tells the consumer that frames are waiting. An arrival sets it when the enable is on. Draining the ring to empty, a flush, or a mask write clears it.

Top module: `rxr_ring`

## Requirements
- R1: After a synchronous reset, `q_count` is 0 and `irq`, `out_valid`, `deq_ack`, `err_drop` and `err_trunc` are all 0.
- R2: A frame of N ≤ MAX_BYTES bytes is stored when its last byte is taken, and `q_count` rises by one on that edge. A later dequeue asserts `deq_ack` for one cycle with `deq_len` = N. The N bytes follow on `out_valid` in arrival order, starting the cycle after `deq_ack`, and `out_last` is set only on the final byte.
- R3: Dequeues return frames oldest first, taken from slot (write index − count) mod DEPTH. This ordering holds when the write index wraps past the last slot.
- R4: A frame whose first byte arrives while `q_count` = DEPTH is discarded whole. `err_drop` pulses for one cycle after its last byte. `q_count` and all stored frames are unchanged.
- R5: A frame longer than MAX_BYTES is stored with length MAX_BYTES and keeps its first MAX_BYTES bytes. `err_trunc` pulses for one cycle after its last byte.
- R6: A dequeue on an empty ring gives `deq_ack` with `deq_len` = 0, and no byte is streamed.
- R7: When a frame is stored while the interrupt enable is 1, `irq` is 1 from the next cycle. When the enable is 0, storing a frame leaves `irq` unchanged.
- R8: The occupancy drops by one on the edge that issues the last byte of a dequeued frame. If the count reaches 0 there, `irq` falls on the same edge.
- R9: A `flush` cycle sets `q_count` to 0, clears `irq`, aborts any byte stream in progress, and ignores a dequeue request in the same cycle. A frame completing in that same cycle is not counted.
- R10: A `mask_wr` cycle loads the enable from `mask_val`. `irq` then becomes `mask_val` AND (count ≠ 0).
- R11: When a frame's last byte and a dequeue request fall in the same cycle, the arrival is applied first. On an empty ring, the dequeue therefore returns the frame that just arrived.
- R12: A dequeue request raised while a byte stream is in progress is ignored: it produces no `deq_ack` and does not change `q_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inbound byte present |
| in_data | input | 8 | Inbound byte |
| in_last | input | 1 | Inbound byte is the last of its frame |
| deq_req | input | 1 | Request to dequeue the oldest frame |
| flush | input | 1 | Empty the ring |
| mask_wr | input | 1 | Load the interrupt enable |
| mask_val | input | 1 | New interrupt enable value |
| deq_ack | output | 1 | One-cycle pulse answering an accepted dequeue request |
| deq_len | output | $clog2(MAX_BYTES+1) | Length of the dequeued frame (0 when the ring was empty) |
| out_valid | output | 1 | Outbound byte present |
| out_data | output | 8 | Outbound byte |
| out_last | output | 1 | Outbound byte is the last of its frame |
| q_count | output | $clog2(DEPTH+1) | Number of frames held |
| irq | output | 1 | Level interrupt |
| err_drop | output | 1 | A frame was discarded because the ring was full |
| err_trunc | output | 1 | A frame was cut to MAX_BYTES |

## Verification
Frame completion and dequeue start can land on the same clock edge. That edge is where the occupancy count and the derived oldest-slot index must agree. The bench provokes this on an empty ring by raising the dequeue request during the cycle that carries a frame's last byte. It then expects `deq_ack` with that frame's own length, its bytes in order, and a count back at zero. A second coincidence, a request raised while a frame is streaming out, is judged by the absence of a second acknowledge and an unchanged count.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  typedef logic [7:0] rxr_byte_t;

  function automatic int unsigned rxr_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rxr_ingress.sv
`timescale 1ns/1ps
module rxr_ingress #(
  parameter int unsigned MAX_BYTES = 512,
  localparam int unsigned LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          ring_full,
  output logic          wr_en,
  output logic [LW-1:0] wr_off,
  output logic          commit,
  output logic [LW-1:0] commit_len,
  output logic          trunc,
  output logic          drop
);
  localparam logic [LW-1:0] MAXV = LW'(MAX_BYTES);

  logic          mid_r;
  logic          keep_r;
  logic [LW-1:0] off_r;
  logic          keep;
  logic [LW-1:0] off;
  logic          room;

  // Accept/drop is decided once, on the first byte of a frame
  always_comb begin
    keep       = mid_r ? keep_r : !ring_full;
    off        = mid_r ? off_r : '0;
    room       = off < MAXV;
    wr_en      = in_valid && keep && room;
    wr_off     = off;
    commit     = in_valid && in_last && keep;
    commit_len = room ? off + LW'(1) : MAXV;
    trunc      = commit && !room;
    drop       = in_valid && in_last && !keep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_r  <= 1'b0;
      keep_r <= 1'b0;
      off_r  <= '0;
    end else if (in_valid) begin
      mid_r  <= !in_last;
      keep_r <= keep;
      off_r  <= room ? off + LW'(1) : MAXV;
    end
  end
endmodule

// File: rtl/rxr_store.sv
`timescale 1ns/1ps
module rxr_store
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned MAX_BYTES = 512,
  localparam int unsigned SW = rxr_bits(DEPTH),
  localparam int unsigned LW = $clog2(MAX_BYTES + 1),
  localparam int unsigned AW = rxr_bits(DEPTH * MAX_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [LW-1:0] wr_off,
  input  rxr_byte_t     wr_data,
  input  logic          len_we,
  input  logic [LW-1:0] len_val,
  input  logic [SW-1:0] len_sel_slot,
  output logic [LW-1:0] len_sel,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_slot,
  input  logic [LW-1:0] rd_off,
  output rxr_byte_t     rd_data
);
  rxr_byte_t     mem [DEPTH*MAX_BYTES];
  logic [AW-1:0] wa;
  logic [AW-1:0] ra;
  logic [LW-1:0] len_arr [DEPTH];

  assign wa = AW'(wr_slot) * AW'(MAX_BYTES) + AW'(wr_off);
  assign ra = AW'(rd_slot) * AW'(MAX_BYTES) + AW'(rd_off);

  // Simple dual-port frame memory, registered read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[ra];
  end

  // One length register per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_len
    logic [LW-1:0] len_q;
    always_ff @(posedge clk) begin
      if (rst) len_q <= '0;
      else if (len_we && wr_slot == SW'(g)) len_q <= len_val;
    end
    assign len_arr[g] = len_q;
  end

  assign len_sel = len_arr[len_sel_slot];
endmodule

// File: rtl/rxr_egress.sv
`timescale 1ns/1ps
module rxr_egress
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned MAX_BYTES = 512,
  localparam int unsigned SW = rxr_bits(DEPTH),
  localparam int unsigned LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] start_slot,
  input  logic [LW-1:0] start_len,
  input  logic          abort,
  output logic          busy,
  output logic          rd_en,
  output logic [SW-1:0] rd_slot,
  output logic [LW-1:0] rd_off,
  output logic          done,
  output logic          ack,
  output logic [LW-1:0] ack_len,
  output logic          out_valid,
  output logic          out_last
);
  logic          busy_r;
  logic [SW-1:0] slot_r;
  logic [LW-1:0] ptr_r;
  logic [LW-1:0] len_r;

  assign busy    = busy_r;
  assign rd_en   = busy_r && !abort;
  assign rd_slot = slot_r;
  assign rd_off  = ptr_r;
  assign done    = rd_en && (ptr_r == len_r - LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_r    <= 1'b0;
      slot_r    <= '0;
      ptr_r     <= '0;
      len_r     <= '0;
      ack       <= 1'b0;
      ack_len   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      ack       <= start;
      out_valid <= rd_en;
      out_last  <= done;
      if (start) ack_len <= start_len;
      if (abort) begin
        busy_r <= 1'b0;
      end else if (start) begin
        busy_r <= start_len != '0;
        slot_r <= start_slot;
        ptr_r  <= '0;
        len_r  <= start_len;
      end else if (busy_r) begin
        if (done) busy_r <= 1'b0;
        else      ptr_r  <= ptr_r + LW'(1);
      end
    end
  end
endmodule

// File: rtl/rxr_ring.sv
`timescale 1ns/1ps
module rxr_ring
  import rxr_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned MAX_BYTES = 512,
  localparam int unsigned SW  = rxr_bits(DEPTH),
  localparam int unsigned SXW = SW + 1,
  localparam int unsigned LW  = $clog2(MAX_BYTES + 1),
  localparam int unsigned CW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          deq_req,
  input  logic          flush,
  input  logic          mask_wr,
  input  logic          mask_val,
  output logic          deq_ack,
  output logic [LW-1:0] deq_len,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [CW-1:0] q_count,
  output logic          irq,
  output logic          err_drop,
  output logic          err_trunc
);
  logic [CW-1:0]  count_r;
  logic [SW-1:0]  wr_idx_r;
  logic           en_r;
  logic           irq_r;
  logic           drop_r;
  logic           trunc_r;

  logic           ring_full;
  logic           wr_en;
  logic [LW-1:0]  wr_off;
  logic           commit;
  logic [LW-1:0]  commit_len;
  logic           trunc;
  logic           drop;

  logic [SXW-1:0] old_sum;
  logic [SW-1:0]  old_slot;
  logic [LW-1:0]  len_sel;
  logic           busy;
  logic           deq_go;
  logic [LW-1:0]  start_len;
  logic           rd_en;
  logic [SW-1:0]  rd_slot;
  logic [LW-1:0]  rd_off;
  logic           done;
  logic [CW-1:0]  count_nx;
  logic [SW-1:0]  wr_idx_inc;

  assign ring_full = count_r == CW'(DEPTH);

  rxr_ingress #(.MAX_BYTES(MAX_BYTES)) u_in (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .ring_full  (ring_full),
    .wr_en      (wr_en),
    .wr_off     (wr_off),
    .commit     (commit),
    .commit_len (commit_len),
    .trunc      (trunc),
    .drop       (drop)
  );

  // Oldest slot = (write index - count) mod DEPTH
  always_comb begin
    old_sum = SXW'(wr_idx_r) + SXW'(DEPTH) - SXW'(count_r);
    if (old_sum >= SXW'(DEPTH)) old_sum = old_sum - SXW'(DEPTH);
    old_slot = SW'(old_sum);
  end

  // Arrival is applied first: an empty ring sees the frame landing now
  assign deq_go    = deq_req && !busy && !flush;
  assign start_len = (count_r != '0) ? len_sel :
                     (commit ? commit_len : '0);

  rxr_store #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_mem (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_slot      (wr_idx_r),
    .wr_off       (wr_off),
    .wr_data      (in_data),
    .len_we       (commit),
    .len_val      (commit_len),
    .len_sel_slot (old_slot),
    .len_sel      (len_sel),
    .rd_en        (rd_en),
    .rd_slot      (rd_slot),
    .rd_off       (rd_off),
    .rd_data      (out_data)
  );

  rxr_egress #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_out (
    .clk        (clk),
    .rst        (rst),
    .start      (deq_go),
    .start_slot (old_slot),
    .start_len  (start_len),
    .abort      (flush),
    .busy       (busy),
    .rd_en      (rd_en),
    .rd_slot    (rd_slot),
    .rd_off     (rd_off),
    .done       (done),
    .ack        (deq_ack),
    .ack_len    (deq_len),
    .out_valid  (out_valid),
    .out_last   (out_last)
  );

  assign wr_idx_inc = (wr_idx_r == SW'(DEPTH - 1)) ? '0 : wr_idx_r + SW'(1);
  assign count_nx   = flush ? '0 : count_r + CW'(commit) - CW'(done);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_r  <= '0;
      wr_idx_r <= '0;
      en_r     <= 1'b0;
      irq_r    <= 1'b0;
      drop_r   <= 1'b0;
      trunc_r  <= 1'b0;
    end else begin
      count_r <= count_nx;
      drop_r  <= drop;
      trunc_r <= trunc;
      if (commit)  wr_idx_r <= wr_idx_inc;
      if (mask_wr) en_r     <= mask_val;
      if (flush)                        irq_r <= 1'b0;
      else if (mask_wr)                 irq_r <= mask_val && (count_nx != '0);
      else if (commit && en_r)          irq_r <= 1'b1;
      else if (done && count_nx == '0)  irq_r <= 1'b0;
    end
  end

  assign q_count   = count_r;
  assign irq       = irq_r;
  assign err_drop  = drop_r;
  assign err_trunc = trunc_r;
endmodule

// File: rtl/rxr_ring_chk.sv
`timescale 1ns/1ps
module rxr_ring_chk #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned MAX_BYTES = 512,
  localparam int unsigned LW = $clog2(MAX_BYTES + 1),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          deq_ack,
  input logic [LW-1:0] deq_len,
  input logic          out_valid,
  input logic          out_last,
  input logic [CW-1:0] q_count,
  input logic          irq,
  input logic          err_drop,
  input logic          err_trunc
);
  logic past_rst = 1'b0;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    if (past_rst) begin
      a_r1_reset_clear: assert (q_count == '0 && !irq && !out_valid && !deq_ack
                                && !err_drop && !err_trunc)
        else $error("R1 reset state wrong");
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  a_r2_last_in_stream: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
    deq_ack |-> deq_len <= LW'(MAX_BYTES));

  a_r6_empty_no_stream: assert property (@(posedge clk) disable iff (rst)
    (deq_ack && deq_len == '0) |=> !out_valid);

  a_r7_irq_needs_frame: assert property (@(posedge clk) disable iff (rst)
    irq |-> q_count != '0);

  a_r8_irq_drop_on_empty: assert property (@(posedge clk) disable iff (rst)
    (out_last && q_count == '0) |-> !irq);

  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (q_count == '0 && !irq && !out_valid));
endmodule

bind rxr_ring rxr_ring_chk #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .deq_ack   (deq_ack),
  .deq_len   (deq_len),
  .out_valid (out_valid),
  .out_last  (out_last),
  .q_count   (q_count),
  .irq       (irq),
  .err_drop  (err_drop),
  .err_trunc (err_trunc)
);

// File: tb/sim_rxr_ring.sv
`timescale 1ns/1ps
module sim_rxr_ring;
  localparam int DEPTH = 4;
  localparam int MAXB  = 512;
  localparam int LW    = $clog2(MAXB + 1);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NV    = 6;
  // Each vector: frame length, first byte value
  localparam logic [15:0] VLEN  [NV] = '{16'd1, 16'd12, 16'd64, 16'd512, 16'd3, 16'd40};
  localparam logic [7:0]  VSEED [NV] = '{8'h05, 8'h20, 8'hF0, 8'h33, 8'hC8, 8'h61};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, deq_req = 1'b0, flush = 1'b0;
  logic mask_wr = 1'b0, mask_val = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic deq_ack, out_valid, out_last, irq, err_drop, err_trunc;
  logic [LW-1:0] deq_len;
  logic [7:0] out_data;
  logic [CW-1:0] q_count;

  int checks = 0;
  int errors = 0;
  logic saw_drop, saw_trunc;

  always #2.5 clk = ~clk;

  rxr_ring #(.DEPTH(DEPTH), .MAX_BYTES(MAXB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .deq_req(deq_req), .flush(flush), .mask_wr(mask_wr), .mask_val(mask_val),
    .deq_ack(deq_ack), .deq_len(deq_len), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .q_count(q_count), .irq(irq), .err_drop(err_drop),
    .err_trunc(err_trunc)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 8'(i);
      in_last  = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    saw_drop  = err_drop;
    saw_trunc = err_trunc;
  endtask

  // Called at the negedge where deq_ack is visible
  task automatic collect(input int exp_len, input logic [7:0] seed, input string req);
    int got = 0;
    int bad = 0;
    for (int c = 0; c < exp_len + 8; c++) begin
      if (out_valid) begin
        if (out_data !== seed + 8'(got)) bad++;
        if (out_last !== (got == exp_len - 1)) bad++;
        got++;
      end
      @(negedge clk);
    end
    chk(got == exp_len && bad == 0, req, got, exp_len);
  endtask

  task automatic deq_check(input int exp_len, input logic [7:0] seed, input string req);
    @(negedge clk);
    deq_req = 1'b1;
    @(negedge clk);
    deq_req = 1'b0;
    chk(deq_ack === 1'b1 && int'(deq_len) == exp_len, req, int'(deq_len), exp_len);
    collect(exp_len, seed, req);
  endtask

  task automatic set_mask(input logic v);
    @(negedge clk);
    mask_wr = 1'b1;
    mask_val = v;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(q_count == 0 && irq == 0 && out_valid == 0 && deq_ack == 0 &&
        err_drop == 0 && err_trunc == 0, "R1", int'(q_count), 0);

    // Vector walk: one in, one out; write index wraps after DEPTH frames (R2, R3)
    for (int v = 0; v < NV; v++) begin
      send_frame(int'(VLEN[v]), VSEED[v]);
      chk(q_count == 1, "R2 count after store", int'(q_count), 1);
      deq_check(int'(VLEN[v]), VSEED[v], "R2 R3 vector frame");
      chk(q_count == 0, "R8 count after drain", int'(q_count), 0);
    end

    // Fill the ring, then a fifth frame is dropped whole (R4)
    for (int k = 0; k < DEPTH; k++) send_frame(8 + k, 8'h40 + 8'(16 * k));
    chk(q_count == DEPTH, "R4 ring full", int'(q_count), DEPTH);
    send_frame(5, 8'hEE);
    chk(saw_drop == 1'b1, "R4 drop flag", int'(saw_drop), 1);
    chk(q_count == DEPTH, "R4 count unchanged", int'(q_count), DEPTH);
    for (int k = 0; k < DEPTH; k++)
      deq_check(8 + k, 8'h40 + 8'(16 * k), "R3 R4 oldest first");
    chk(q_count == 0, "R4 drained", int'(q_count), 0);

    // Oversize frame (R5)
    send_frame(MAXB + 3, 8'h77);
    chk(saw_trunc == 1'b1, "R5 trunc flag", int'(saw_trunc), 1);
    deq_check(MAXB, 8'h77, "R5 truncated frame");

    // Empty dequeue (R6)
    deq_check(0, 8'h00, "R6 empty dequeue");

    // Interrupt behaviour (R7, R8, R10)
    set_mask(1'b1);
    chk(irq == 0, "R10 enable on empty ring", int'(irq), 0);
    send_frame(4, 8'h11);
    chk(irq == 1, "R7 irq on arrival", int'(irq), 1);
    deq_check(4, 8'h11, "R7 frame");
    chk(irq == 0, "R8 irq clear on drain", int'(irq), 0);
    set_mask(1'b0);
    send_frame(3, 8'h22);
    chk(irq == 0, "R7 masked arrival", int'(irq), 0);
    set_mask(1'b1);
    chk(irq == 1, "R10 unmask with frame", int'(irq), 1);

    // Flush (R9)
    send_frame(2, 8'h33);
    do_flush();
    chk(q_count == 0 && irq == 0, "R9 flush clears", int'(q_count), 0);
    deq_check(0, 8'h00, "R9 empty after flush");

    // Arrival and dequeue in the same cycle on empty ring (R11)
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h90 + 8'(i);
      in_last  = (i == 3);
      deq_req  = (i == 3);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    deq_req  = 1'b0;
    chk(deq_ack === 1'b1 && deq_len == 4, "R11 same-cycle ack", int'(deq_len), 4);
    collect(4, 8'h90, "R11 same-cycle data");
    chk(q_count == 0, "R11 count after", int'(q_count), 0);

    // Request while streaming is ignored (R12)
    send_frame(6, 8'hA0);
    send_frame(7, 8'hB0);
    @(negedge clk);
    deq_req = 1'b1;
    @(negedge clk);
    chk(deq_ack === 1'b1 && deq_len == 6, "R12 first ack", int'(deq_len), 6);
    @(negedge clk);
    deq_req = 1'b0;
    chk(deq_ack == 1'b0, "R12 no second ack", int'(deq_ack), 0);
    collect(6, 8'hA0, "R12 first frame only");
    chk(q_count == 1, "R12 count", int'(q_count), 1);
    deq_check(7, 8'hB0, "R12 second frame");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule